// File: doc/BRIEF.md
# Bus Sync-Break Detector

This block watches the sampled level of a single-wire bus that has a dominant and a recessive state. A long dominant period tells the slave to drop its protocol state. When the line has stayed dominant for at least a programmable minimum time and then returns to recessive, the block reports a sync break. The break is confirmed at that return, not while the line is still held. Each break produces three pulses. One restarts the protocol handler. One clears the master and slave rolling counters to zero. One aborts every queued transmission.

Breaks are counted. Any valid frame reported by the frame decoder clears the count. A run of breaks with no valid frame between them shows that communication is badly lost. When the run reaches a fixed limit (six by default), the block also asks for a reset of the whole device. It then starts the count again. Time is measured in microseconds by a prescaler built from the clock rate. The four selectable minimum times and the escalation limit are parameters.

Top module: `sync_break_det`

## Requirements
- R1: `bus_rx_i` = 0 means dominant and 1 means recessive. A break is reported only on the first recessive sample after a dominant run that was long enough. The pulses are high in the clock cycle right after that sample.
- R2: `thr_sel_i` codes 0, 1, 2 and 3 select TH0_US, TH1_US, TH2_US and TH3_US microseconds, with CYC_PER_US clock cycles per microsecond. A break needs at least TH×CYC_PER_US consecutive dominant samples. One sample fewer gives no output.
- R3: Every output is a pulse exactly one clock cycle wide.
- R4: A dominant run is timed against the code sampled on the last recessive cycle before it. Changes of `thr_sel_i` during the dominant run have no effect on that run.
- R5: After reset the code in use is 3. A dominant run that begins straight out of reset is timed against TH3_US, whatever `thr_sel_i` is.
- R6: A dominant run shorter than the selected time gives no output and does not advance the break count.
- R7: The dominant timer saturates. A dominant run of any length above the limit is still reported as a break.
- R8: `proto_rst_o`, `roll_clr_o` and `tx_abort_o` rise together, once for each break.
- R9: On the BREAK_LIMIT-th break with no valid frame since the count was last cleared, `dev_rst_o` pulses in the same cycle as the break pulses. The count then restarts from zero.
- R10: A `frm_ok_i` strobe clears the break count.
- R11: `dev_rst_o` is never high without `proto_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_rx_i | input | 1 | Sampled bus level (0 dominant, 1 recessive) |
| thr_sel_i | input | 2 | Minimum dominant time code |
| frm_ok_i | input | 1 | One-cycle strobe for a valid received frame |
| proto_rst_o | output | 1 | Protocol handler restart pulse |
| roll_clr_o | output | 1 | Rolling-counter clear pulse |
| tx_abort_o | output | 1 | Pending-transmission abort pulse |
| dev_rst_o | output | 1 | Whole-device reset request pulse |

## Verification
The checker assumes that `bus_rx_i` is already synchronous to `clk_i` and holds one value for each whole cycle. It also assumes that `frm_ok_i` is a single-cycle strobe. Every stimulus is therefore driven on the falling edge and held across the next rising edge.

The minimum-run check in the checker compares each break against the smallest threshold only. It treats the threshold code as an uncontrolled input. The bench runs the scaled-down timing and steps each code through its exact boundary. It moves `thr_sel_i` in the middle of a dominant run. It also mixes short glitches into the break runs, so that the escalation count is reached only by real breaks.

// File: rtl/sbk_pkg.sv
package sbk_pkg;
   // threshold code as presented on thr_sel_i
   typedef enum logic [1:0] {
      THR_SHORT = 2'd0,
      THR_MID   = 2'd1,
      THR_LONG  = 2'd2,
      THR_MAX   = 2'd3
   } sbk_thr_e;

   localparam sbk_thr_e THR_RESET = THR_MAX;

   // event bundle registered at the block edge
   typedef struct packed {
      logic brk;
      logic dev;
   } sbk_evt_t;
endpackage

// File: rtl/sbk_us_tick.sv
module sbk_us_tick #(
   parameter int unsigned DIV = 200
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic tick_o
);
   generate
      if (DIV == 1) begin : g_direct
         assign tick_o = run_i;
      end else begin : g_div
         localparam int unsigned CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)            cnt_q <= '0;
            else if (!run_i)        cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end

         assign tick_o = run_i && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/sbk_dom_timer.sv
module sbk_dom_timer
   import sbk_pkg::*;
#(
   parameter int unsigned DOM_W  = 10,
   parameter int unsigned TH0_US = 100,
   parameter int unsigned TH1_US = 250,
   parameter int unsigned TH2_US = 750,
   parameter int unsigned TH3_US = 1000
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       bus_rx_i,
   input  logic [1:0] thr_sel_i,
   input  logic       tick_i,
   output logic       brk_o
);
   localparam logic [DOM_W-1:0] LIM0 = DOM_W'(TH0_US);
   localparam logic [DOM_W-1:0] LIM1 = DOM_W'(TH1_US);
   localparam logic [DOM_W-1:0] LIM2 = DOM_W'(TH2_US);
   localparam logic [DOM_W-1:0] LIM3 = DOM_W'(TH3_US);

   sbk_thr_e         thr_q;
   logic             bus_q;
   logic [DOM_W-1:0] dom_us_q;
   logic [DOM_W-1:0] lim;

   // code is captured only while the line idles recessive
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       thr_q <= THR_RESET;
      else if (bus_rx_i) thr_q <= sbk_thr_e'(thr_sel_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bus_q <= 1'b1;
      else         bus_q <= bus_rx_i;
   end

   // saturating microsecond count of the current dominant run
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         dom_us_q <= '0;
      else if (bus_rx_i)                   dom_us_q <= '0;
      else if (tick_i && (dom_us_q != '1)) dom_us_q <= dom_us_q + 1'b1;
   end

   always_comb begin
      unique case (thr_q)
         THR_SHORT: lim = LIM0;
         THR_MID:   lim = LIM1;
         THR_LONG:  lim = LIM2;
         default:   lim = LIM3;
      endcase
   end

   assign brk_o = bus_rx_i && !bus_q && (dom_us_q >= lim);
endmodule

// File: rtl/sbk_brk_count.sv
module sbk_brk_count #(
   parameter int unsigned LIMIT = 6,
   parameter int unsigned CW    = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic brk_i,
   input  logic frm_ok_i,
   output logic dev_o
);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] base;

   // a valid frame clears first; a break in the same cycle then counts as one
   assign base  = frm_ok_i ? '0 : cnt_q;
   assign dev_o = brk_i && (base == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (dev_o) cnt_q <= '0;
      else if (brk_i) cnt_q <= base + 1'b1;
      else            cnt_q <= base;
   end
endmodule

// File: rtl/sync_break_det.sv
module sync_break_det
   import sbk_pkg::*;
#(
   parameter int unsigned CYC_PER_US  = 200,
   parameter int unsigned TH0_US      = 100,
   parameter int unsigned TH1_US      = 250,
   parameter int unsigned TH2_US      = 750,
   parameter int unsigned TH3_US      = 1000,
   parameter int unsigned BREAK_LIMIT = 6
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       bus_rx_i,
   input  logic [1:0] thr_sel_i,
   input  logic       frm_ok_i,
   output logic       proto_rst_o,
   output logic       roll_clr_o,
   output logic       tx_abort_o,
   output logic       dev_rst_o
);
   localparam int unsigned DOM_W = $clog2(TH3_US + 1);
   localparam int unsigned CNT_W = $clog2(BREAK_LIMIT + 1);

   generate
      if (CYC_PER_US < 1) begin : g_bad_div
         $error("CYC_PER_US must be at least 1");
      end
      if (TH0_US < 1 || TH0_US > TH1_US || TH1_US > TH2_US || TH2_US > TH3_US) begin : g_bad_thr
         $error("thresholds must be non-zero and ascending");
      end
      if (BREAK_LIMIT < 2) begin : g_bad_limit
         $error("BREAK_LIMIT must be at least 2");
      end
   endgenerate

   logic     tick;
   logic     brk;
   logic     dev;
   sbk_evt_t evt_q;

   sbk_us_tick #(.DIV(CYC_PER_US)) u_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (!bus_rx_i),
      .tick_o (tick)
   );

   sbk_dom_timer #(
      .DOM_W (DOM_W),
      .TH0_US(TH0_US),
      .TH1_US(TH1_US),
      .TH2_US(TH2_US),
      .TH3_US(TH3_US)
   ) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .bus_rx_i (bus_rx_i),
      .thr_sel_i(thr_sel_i),
      .tick_i   (tick),
      .brk_o    (brk)
   );

   sbk_brk_count #(.LIMIT(BREAK_LIMIT), .CW(CNT_W)) u_count (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .brk_i   (brk),
      .frm_ok_i(frm_ok_i),
      .dev_o   (dev)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) evt_q <= '0;
      else         evt_q <= '{brk: brk, dev: dev};
   end

   assign proto_rst_o = evt_q.brk;
   assign roll_clr_o  = evt_q.brk;
   assign tx_abort_o  = evt_q.brk;
   assign dev_rst_o   = evt_q.dev;
endmodule

// File: rtl/sbk_sync_break_chk.sv
module sbk_sync_break_chk #(
   parameter int unsigned MIN_CYC = 2
) (
   input logic clk_i,
   input logic rst_ni,
   input logic bus_rx_i,
   input logic proto_rst_o,
   input logic roll_clr_o,
   input logic tx_abort_o,
   input logic dev_rst_o
);
   // consecutive dominant samples seen on the pin, saturating
   logic [31:0] run_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           run_q <= '0;
      else if (bus_rx_i)     run_q <= '0;
      else if (run_q != '1)  run_q <= run_q + 1'b1;
   end

   a_r1_on_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
      proto_rst_o |-> ($past(bus_rx_i) && !$past(bus_rx_i, 2)));

   a_r2_min_dominant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      proto_rst_o |-> ($past(run_q) >= MIN_CYC));

   a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (proto_rst_o || dev_rst_o) |=> (!proto_rst_o && !dev_rst_o));

   a_r8_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (proto_rst_o == roll_clr_o) && (proto_rst_o == tx_abort_o));

   a_r11_dev_with_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dev_rst_o |-> proto_rst_o);
endmodule

bind sync_break_det sbk_sync_break_chk #(.MIN_CYC(TH0_US * CYC_PER_US)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .bus_rx_i   (bus_rx_i),
   .proto_rst_o(proto_rst_o),
   .roll_clr_o (roll_clr_o),
   .tx_abort_o (tx_abort_o),
   .dev_rst_o  (dev_rst_o)
);

// File: tb/sync_break_det_bench.sv
`timescale 1ns/1ps
module sync_break_det_bench;
   // scaled timing: 2 cycles per us, thresholds 4/8/12/16 us -> 8/16/24/32 samples
   localparam int unsigned DIV = 2;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       bus_rx_i = 1'b1;
   logic [1:0] thr_sel_i = 2'd0;
   logic       frm_ok_i = 1'b0;
   logic       proto_rst_o, roll_clr_o, tx_abort_o, dev_rst_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk_i = ~clk_i;

   sync_break_det #(
      .CYC_PER_US(DIV), .TH0_US(4), .TH1_US(8), .TH2_US(12), .TH3_US(16), .BREAK_LIMIT(6)
   ) u_sync_break_det (
      .clk_i(clk_i), .rst_ni(rst_ni), .bus_rx_i(bus_rx_i), .thr_sel_i(thr_sel_i),
      .frm_ok_i(frm_ok_i), .proto_rst_o(proto_rst_o), .roll_clr_o(roll_clr_o),
      .tx_abort_o(tx_abort_o), .dev_rst_o(dev_rst_o)
   );

   // {sel before run, sel mid run, dominant samples, break expected}
   localparam int NV = 11;
   localparam logic [12:0] VEC [NV] = '{
      {2'd0, 2'd0, 8'd7,  1'b0},   // R2 one short of code 0
      {2'd0, 2'd0, 8'd8,  1'b1},   // R2 code 0 exact
      {2'd1, 2'd1, 8'd15, 1'b0},   // R2
      {2'd1, 2'd1, 8'd16, 1'b1},   // R2
      {2'd2, 2'd2, 8'd23, 1'b0},   // R2
      {2'd2, 2'd2, 8'd24, 1'b1},   // R2
      {2'd3, 2'd3, 8'd31, 1'b0},   // R2
      {2'd3, 2'd3, 8'd32, 1'b1},   // R2
      {2'd3, 2'd0, 8'd20, 1'b0},   // R4 lowered code mid run ignored
      {2'd0, 2'd3, 8'd10, 1'b1},   // R4 raised code mid run ignored
      {2'd3, 2'd3, 8'd68, 1'b1}    // R7 timer would wrap to 2 us
   };

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: %s act=%0b exp=%0b", req, what, act, exp);
      end
   endtask

   task automatic chk_outs(input string req, input logic eb, input logic ed);
      chk(req, "proto_rst_o", proto_rst_o, eb);
      chk(req, "roll_clr_o",  roll_clr_o,  eb);
      chk(req, "tx_abort_o",  tx_abort_o,  eb);
      chk(req, "dev_rst_o",   dev_rst_o,   ed);
   endtask

   // one recessive sample loads sel, n dominant samples, then recessive return
   task automatic run_dom(input string req, input logic [1:0] sel, input logic [1:0] mid,
                          input int n, input logic eb, input logic ed);
      bus_rx_i  = 1'b1;
      thr_sel_i = sel;
      @(negedge clk_i);
      bus_rx_i = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (i == n / 2) thr_sel_i = mid;
         @(negedge clk_i);
      end
      bus_rx_i = 1'b1;
      @(negedge clk_i);
      chk_outs(req, eb, ed);
      @(negedge clk_i);
      chk_outs("R3", 1'b0, 1'b0);
   endtask

   task automatic frame_ok();
      frm_ok_i = 1'b1;
      @(negedge clk_i);
      frm_ok_i = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // reset state
      repeat (3) @(negedge clk_i);
      chk_outs("R3", 1'b0, 1'b0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      chk_outs("R1", 1'b0, 1'b0);

      // table walk, count cleared before each run
      for (int v = 0; v < NV; v++) begin
         frame_ok();
         run_dom("R2", VEC[v][12:11], VEC[v][10:9], int'(VEC[v][8:1]), VEC[v][0], 1'b0);
      end

      // R5: dominant straight out of reset uses code 3
      rst_ni = 1'b0; bus_rx_i = 1'b0; thr_sel_i = 2'd0;
      repeat (2) @(negedge clk_i);
      rst_ni = 1'b1;
      repeat (31) @(negedge clk_i);
      bus_rx_i = 1'b1;
      @(negedge clk_i);
      chk_outs("R5", 1'b0, 1'b0);
      rst_ni = 1'b0; bus_rx_i = 1'b0;
      repeat (2) @(negedge clk_i);
      rst_ni = 1'b1;
      repeat (32) @(negedge clk_i);
      bus_rx_i = 1'b1;
      @(negedge clk_i);
      chk_outs("R5", 1'b1, 1'b0);
      @(negedge clk_i);

      // R9 and R6: short glitches between breaks do not count
      frame_ok();
      for (int k = 0; k < 5; k++) begin
         run_dom("R9", 2'd0, 2'd0, 8, 1'b1, 1'b0);
         run_dom("R6", 2'd0, 2'd0, 3, 1'b0, 1'b0);
      end
      run_dom("R9", 2'd0, 2'd0, 8, 1'b1, 1'b1);
      run_dom("R9", 2'd0, 2'd0, 8, 1'b1, 1'b0);   // count restarted

      // R10: a valid frame restarts the run
      frame_ok();
      for (int k = 0; k < 3; k++) run_dom("R10", 2'd0, 2'd0, 8, 1'b1, 1'b0);
      frame_ok();
      for (int k = 0; k < 5; k++) run_dom("R10", 2'd0, 2'd0, 8, 1'b1, 1'b0);
      run_dom("R11", 2'd0, 2'd0, 8, 1'b1, 1'b1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule